// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator

This block holds four alarm registers: seconds, minutes, hours and date. On each one-second tick from the timekeeper it compares the live BCD time against them. When every field that is not masked agrees, it sets an alarm flag. If the alarm interrupt enable is high, it also sets an interrupt request flag. A watchdog event from elsewhere in the clock chip also sets the interrupt request flag.

Bit 7 of each alarm register is a don't-care mask for that field. Masking a field lets the alarm repeat every minute, hour or day. Masking all four fields turns the alarm into an update interrupt that fires every second.

Software reads both flags from the control-A location of the register port. That read also clears them. An active-low interrupt pin follows the interrupt request flag.

Top module: `alarm_match_unit`

## Requirements
- R1: A write (`wr_en`) to address 0x8, 0x9, 0xA or 0xB stores all 8 bits of `wdata` into the alarm register for seconds, minutes, hours or date, in that order. A read (`rd_en`) of these addresses presents the stored byte on `rdata` one clock later. A read of any address other than 0x8 to 0xB and 0xE returns 0.
- R2: The comparison uses bits 6:0 of the seconds and minutes alarm registers, and bits 5:0 of the hours and date alarm registers. Bit 6 of the hours and date registers does not take part.
- R3: When bit 7 of an alarm register is 1, that field counts as matching whatever the live time is.
- R4: With bit 7 set in all four alarm registers, every tick produces an alarm event.
- R5: A match is evaluated only in a cycle where `tick` is high. A matching time without a tick sets no flag.
- R6: An alarm event sets `alarm_flag` on the clock edge that samples the tick. The flag then holds until a control-A read clears it.
- R7: An alarm event also sets `irq_flag` when `alarm_ie` is 1. When `alarm_ie` is 0, the alarm event leaves `irq_flag` unchanged.
- R8: A high `wdog_evt` sets `irq_flag` on that edge, whatever the alarm state is.
- R9: A read of address 0xE returns `{4'b0, alarm_flag, 2'b0, irq_flag}` one clock later. Bit 3 is the alarm flag and bit 0 is the interrupt request flag. The values returned are those held before the read, and the read then clears both flags.
- R10: When a flag is set and cleared in the same cycle, the set wins, so the new event survives the control-A read.
- R11: `irq_n` is low exactly while `irq_flag` is 1.
- R12: After reset the alarm registers, both flags and `rdata` are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse on each seconds update |
| cur_sec | input | 7 | Live seconds, BCD |
| cur_min | input | 7 | Live minutes, BCD |
| cur_hour | input | 6 | Live hours, BCD |
| cur_date | input | 6 | Live day of month, BCD |
| alarm_ie | input | 1 | Alarm interrupt enable from control B |
| wdog_evt | input | 1 | Watchdog timeout event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| alarm_flag | output | 1 | Alarm flag (control A bit 3) |
| irq_flag | output | 1 | Interrupt request flag (control A bit 0) |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
A matching tick can arrive in the same cycle as the control-A read that clears the flags. The bench provokes this in a directed case, and also lets random reads fall on random matching ticks. It judges the result by two things. The read data must carry the flags held before that edge. The flags must read as set afterwards. A watchdog event coinciding with a clearing read is judged the same way.

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    cur_sec,
  input  logic [6:0]    cur_min,
  input  logic [5:0]    cur_hour,
  input  logic [5:0]    cur_date,
  input  logic          alarm_ie,
  input  logic          wdog_evt,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          alarm_flag,
  output logic          irq_flag,
  output logic          irq_n
);
  localparam logic [3:0] CTL_ADDR = 4'hE;
  localparam int MSK = DW - 1;

  logic [DW-1:0] al_q [4];
  logic          in_alarm_win, ctl_rd, hit, irq_set;
  logic          m_sec, m_min, m_hour, m_date;

  assign in_alarm_win = (addr[3:2] == 2'b10);
  assign ctl_rd       = rd_en && (addr == CTL_ADDR);

  assign m_sec  = al_q[0][MSK] || (al_q[0][6:0] == cur_sec);
  assign m_min  = al_q[1][MSK] || (al_q[1][6:0] == cur_min);
  assign m_hour = al_q[2][MSK] || (al_q[2][5:0] == cur_hour);
  assign m_date = al_q[3][MSK] || (al_q[3][5:0] == cur_date);

  assign hit     = tick && m_sec && m_min && m_hour && m_date;
  assign irq_set = (hit && alarm_ie) || wdog_evt;
  assign irq_n   = ~irq_flag;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_alarm_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          al_q[g] <= '0;
        else if (wr_en && in_alarm_win && (addr[1:0] == 2'(g)))
          al_q[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
      irq_flag   <= 1'b0;
    end else begin
      if (hit)          alarm_flag <= 1'b1;
      else if (ctl_rd)  alarm_flag <= 1'b0;
      if (irq_set)      irq_flag   <= 1'b1;
      else if (ctl_rd)  irq_flag   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en) begin
      if (in_alarm_win)
        rdata <= al_q[addr[1:0]];
      else if (addr == CTL_ADDR)
        rdata <= DW'({4'b0, alarm_flag, 2'b0, irq_flag});
      else
        rdata <= '0;
    end
  end
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          alarm_ie,
  input logic          wdog_evt,
  input logic          rd_en,
  input logic [3:0]    addr,
  input logic [DW-1:0] rdata,
  input logic          alarm_flag,
  input logic          irq_flag,
  input logic          irq_n
);
  logic ctl_rd;
  assign ctl_rd = rd_en && (addr == 4'hE);

  p_flag_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(wdog_evt) || ($past(tick) && $past(alarm_ie))));

  p_alarm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !ctl_rd) |=> alarm_flag);

  p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !tick && !wdog_evt) |=> (!alarm_flag && !irq_flag));

  p_ctl_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> (rdata == DW'({4'b0, $past(alarm_flag), 2'b0, $past(irq_flag)})));

  p_wdog_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt |=> (irq_flag && !irq_n));
endmodule

bind alarm_match_unit alarm_match_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_ie(alarm_ie),
  .wdog_evt(wdog_evt), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .alarm_flag(alarm_flag), .irq_flag(irq_flag), .irq_n(irq_n)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
  logic       clk = 0, rst_n = 0, tick = 0, alarm_ie = 0, wdog_evt = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [6:0] cur_sec = 0, cur_min = 0;
  logic [5:0] cur_hour = 0, cur_date = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       alarm_flag, irq_flag, irq_n;
  int checks = 0, fails = 0;
  logic [7:0] m_al [4];
  logic       m_af = 0, m_irq = 0;

  always #10 clk = ~clk;

  alarm_match_unit i_alarm_match_unit (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(logic [6:0] s, logic [6:0] mi, logic [5:0] h, logic [5:0] d);
    return (m_al[0][7] || m_al[0][6:0] == s) && (m_al[1][7] || m_al[1][6:0] == mi) &&
           (m_al[2][7] || m_al[2][5:0] == h) && (m_al[3][7] || m_al[3][5:0] == d);
  endfunction

  function automatic logic [7:0] ctl_byte(bit af, bit iq);
    return {4'b0, af, 2'b0, iq};
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    if (a[3:2] == 2'b10) m_al[a[1:0]] = d;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  // one cycle with optional tick, read of control A and watchdog event
  task automatic step(logic [6:0] s, logic [6:0] mi, logic [5:0] h, logic [5:0] d,
                      bit tk, bit ie, bit rdc, bit wd, string req);
    bit hit;
    logic [7:0] exp_rd;
    @(negedge clk);
    cur_sec = s; cur_min = mi; cur_hour = h; cur_date = d;
    tick = tk; alarm_ie = ie; wdog_evt = wd; rd_en = rdc; addr = 4'hE;
    hit = tk && exp_hit(s, mi, h, d);
    exp_rd = ctl_byte(m_af, m_irq);
    if (hit) m_af = 1; else if (rdc) m_af = 0;
    if ((hit && ie) || wd) m_irq = 1; else if (rdc) m_irq = 0;
    @(negedge clk);
    tick = 0; wdog_evt = 0; rd_en = 0;
    check({req, " alarm_flag"}, alarm_flag, m_af);
    check({req, " irq_flag"}, irq_flag, m_irq);
    check("R11 irq_n", irq_n, !m_irq);
    if (rdc) check({req, " R9 rdata"}, rdata, exp_rd);
  endtask

  task automatic clear_flags();
    logic [7:0] v;
    rd(4'hE, v);
    m_af = 0; m_irq = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1511));
    for (int i = 0; i < 4; i++) m_al[i] = 0;
    repeat (3) @(negedge clk);
    check("R12 rdata", rdata, 0);
    check("R12 alarm_flag", alarm_flag, 0);
    check("R12 irq_flag", irq_flag, 0);
    check("R12 irq_n", irq_n, 1);
    rst_n = 1;
    rd(4'h8, v); check("R12 alarm reg", v, 0);

    wr(4'h8, 8'h45); wr(4'h9, 8'h30); wr(4'hA, 8'h12); wr(4'hB, 8'h25);
    rd(4'h8, v); check("R1 sec reg", v, 8'h45);
    rd(4'hB, v); check("R1 date reg", v, 8'h25);
    rd(4'h3, v); check("R1 other addr", v, 0);

    step(7'h45, 7'h30, 6'h12, 6'h25, 0, 1, 0, 0, "R5 no tick");
    step(7'h44, 7'h30, 6'h12, 6'h25, 1, 1, 0, 0, "R2 sec mismatch");
    step(7'h45, 7'h30, 6'h12, 6'h25, 1, 0, 0, 0, "R6 match ie=0 R7");
    step(7'h00, 7'h00, 6'h00, 6'h00, 0, 0, 0, 0, "R6 hold");
    step(7'h00, 7'h00, 6'h00, 6'h00, 0, 0, 1, 0, "R9 clear");
    step(7'h45, 7'h30, 6'h12, 6'h25, 1, 1, 0, 0, "R7 match ie=1");
    step(7'h45, 7'h30, 6'h12, 6'h25, 1, 1, 1, 0, "R10 match with read");
    clear_flags();

    wr(4'hA, 8'h52);
    step(7'h45, 7'h30, 6'h12, 6'h25, 1, 1, 0, 0, "R2 hour bit6 ignored");
    clear_flags();
    wr(4'h8, 8'hC5);
    step(7'h07, 7'h30, 6'h12, 6'h25, 1, 1, 0, 0, "R3 sec masked");
    clear_flags();
    wr(4'h8, 8'h80); wr(4'h9, 8'h80); wr(4'hA, 8'h80); wr(4'hB, 8'h80);
    step(7'h13, 7'h57, 6'h03, 6'h31, 1, 1, 0, 0, "R4 all masked");
    step(7'h14, 7'h57, 6'h03, 6'h31, 1, 1, 1, 0, "R4 every tick R10");
    clear_flags();
    step(7'h00, 7'h00, 6'h00, 6'h00, 0, 0, 0, 1, "R8 watchdog");
    step(7'h00, 7'h00, 6'h00, 6'h00, 0, 0, 1, 1, "R8 R10 watchdog with read");
    clear_flags();

    for (int n = 0; n < 400; n++) begin
      logic [6:0] s, mi; logic [5:0] h, d;
      if ($urandom % 4 == 0) begin
        int k = $urandom % 4;
        wr(4'(8 + k), 8'($urandom));
      end
      if ($urandom % 2 == 0) begin
        s = m_al[0][6:0]; mi = m_al[1][6:0]; h = m_al[2][5:0]; d = m_al[3][5:0];
        if ($urandom % 3 == 0) s = 7'($urandom);
      end else begin
        s = 7'($urandom); mi = 7'($urandom); h = 6'($urandom); d = 6'($urandom);
      end
      step(s, mi, h, d, 1'($urandom), 1'($urandom), ($urandom % 3 == 0),
           ($urandom % 10 == 0), "R3 R6 R7 R9 random");
      if ($urandom % 16 == 0) begin
        int k = $urandom % 4;
        rd(4'(8 + k), v); check("R1 random readback", v, m_al[k]);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule